// File: doc/BRIEF.md
# Affinity-based working-set bipartitioner

This block watches a stream of cache-line addresses, at most one per clock, and gives each tracked line a signed affinity. Over time the sign of that affinity splits the tracked working set into two groups of similar size. Lines that are often requested close together end up on the same side. A logic block that decides which core should run a sequential task can use the sign of a line's affinity to choose the core that owns it.

The block keeps a short recency window of the most recently requested distinct lines, together with a running sum of their affinities. On every request, lines inside the window move one step in the direction of the sum's sign and all other lines move one step the opposite way. Nothing is walked per line. A single global drift register carries the whole shift, and each line's stored word is kept offset by that register. The offset is subtracted for lines in the window and added for lines outside it. A line that joins or leaves the window has its stored word converted in the same cycle. Lines outside the window live in a small direct-mapped table indexed by the low address bits.

Top module: `abp_bipartitioner`

## Requirements
- R1: After a synchronous active-high reset, `rsp_valid`, `rsp_affinity` and `rsp_sum_neg` are 0, the window and table are empty, and the drift and window sum are zero.
- R2: `rsp_valid` is high exactly in the cycle after a cycle with `req_valid` high. `rsp_affinity` and `rsp_sum_neg` hold their values through cycles without a request.
- R3: A requested line that is in neither the window nor the table (its table slot, selected by the low `IDX_W` address bits, is empty or holds a different upper-bit tag) reports affinity 0.
- R4: Let S be the window sum before a request. The step is +1 when S is zero or positive and -1 when S is negative. `rsp_sum_neg` is 1 exactly when S < 0.
- R5: On each request, every line in the window after that request's window update gains the step, and every line held in the table loses it.
- R6: The window holds at most `WIN_N` distinct lines in recency order. A request for a line already in the window moves it to the most-recent place and removes nothing. Any other request inserts the line as most recent and, when the window is full, removes the least recent line.
- R7: The window sum always equals the sum of the current affinities of the lines in the window. It is therefore observable through `rsp_sum_neg` on the next request.
- R8: A cycle without a request changes no affinity, no window contents and no sum.
- R9: A line removed from the window is written to its table slot, replacing any earlier occupant. It keeps its affinity there and keeps losing the step until it is requested again.
- R10: `rsp_affinity` reports the requested line's affinity before that request's update, as a two's-complement `VAL_W`-bit value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A line request is present this cycle |
| req_line | input | LINE_W | Cache-line address of the request |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_affinity | output | VAL_W | Affinity of the requested line before the update, signed |
| rsp_sum_neg | output | 1 | Window sum was negative when the request arrived |

## Verification
The hardest situation to reach is a negative window sum. While the window sum is zero or positive, lines in the window only grow, so the sum cannot turn negative on its own. The bench therefore first hammers a small set of lines that all fit in the window for many requests. During that time every line parked in the table keeps losing one per request. It then requests those parked lines, which pulls strongly negative values into the window and flips the sum. After that, a section of lines that all map to the same table slot, followed by a long pseudo-random stream with idle gaps, exercises table replacement, the conversions on entry and exit, and the hold behaviour.

// File: rtl/abp_pkg.sv
package abp_pkg;

  // Where the affinity of a requested line was found.
  typedef enum logic [1:0] {
    LK_WINDOW = 2'd0,
    LK_TABLE  = 2'd1,
    LK_FRESH  = 2'd2
  } lookup_src_e;

endpackage

// File: rtl/abp_table.sv
module abp_table #(
  parameter int IDX_W = 4,
  parameter int TAG_W = 4,
  parameter int VAL_W = 16,
  localparam int DEPTH = 1 << IDX_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_vld,
  output logic [TAG_W-1:0] rd_tag,
  output logic [VAL_W-1:0] rd_val,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic [VAL_W-1:0] wr_val
);

  logic [TAG_W-1:0] tag_mem [DEPTH];
  logic [VAL_W-1:0] val_mem [DEPTH];
  logic [DEPTH-1:0] vld_q;

  // Data arrays: plain write port, no reset, so they map to memory.
  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_mem[wr_idx] <= wr_tag;
      val_mem[wr_idx] <= wr_val;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= '0;
    end else if (wr_en) begin
      vld_q[wr_idx] <= 1'b1;
    end
  end

  assign rd_vld = vld_q[rd_idx];
  assign rd_tag = tag_mem[rd_idx];
  assign rd_val = val_mem[rd_idx];

  // R9: a line written back from the window occupies its slot afterwards.
  assert_writeback_kept_R9: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> vld_q[$past(wr_idx)]);

endmodule

// File: rtl/abp_window.sv
module abp_window #(
  parameter int WIN_N  = 4,
  parameter int LINE_W = 8,
  parameter int VAL_W  = 16,
  localparam int PW    = $clog2(WIN_N),
  localparam int CNT_W = $clog2(WIN_N + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              upd_en,
  input  logic [LINE_W-1:0] lk_line,
  input  logic [VAL_W-1:0]  ins_val,
  output logic              hit,
  output logic [VAL_W-1:0]  hit_val,
  output logic              evict_vld,
  output logic [LINE_W-1:0] evict_line,
  output logic [VAL_W-1:0]  evict_val,
  output logic [CNT_W-1:0]  cnt_next
);

  // Slot 0 is the most recent entry, slot WIN_N-1 the least recent.
  logic [LINE_W-1:0] line_q [WIN_N];
  logic [VAL_W-1:0]  val_q  [WIN_N];
  logic [WIN_N-1:0]  vld_q;
  logic [WIN_N-1:0]  match;
  logic [PW-1:0]     hit_pos;
  logic [CNT_W-1:0]  cnt_now;

  for (genvar g = 0; g < WIN_N; g++) begin : g_cmp
    assign match[g] = vld_q[g] && (line_q[g] == lk_line);
  end

  always_comb begin
    hit_pos = '0;
    hit_val = '0;
    for (int i = 0; i < WIN_N; i++) begin
      if (match[i]) begin
        hit_pos = PW'(i);
        hit_val = val_q[i];
      end
    end
  end

  assign hit = |match;

  always_comb begin
    cnt_now = '0;
    for (int i = 0; i < WIN_N; i++) begin
      cnt_now = cnt_now + CNT_W'(vld_q[i]);
    end
  end

  assign evict_vld  = !hit && vld_q[WIN_N-1];
  assign evict_line = line_q[WIN_N-1];
  assign evict_val  = val_q[WIN_N-1];
  assign cnt_next   = (hit || vld_q[WIN_N-1]) ? cnt_now : cnt_now + CNT_W'(1);

  // Slot 0 always receives the requested line.
  always_ff @(posedge clk) begin
    if (upd_en) begin
      line_q[0] <= lk_line;
      val_q[0]  <= hit ? hit_val : ins_val;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q[0] <= 1'b0;
    end else if (upd_en) begin
      vld_q[0] <= 1'b1;
    end
  end

  // Older slots shift down by one up to the hit position (or all on a miss).
  for (genvar g = 1; g < WIN_N; g++) begin : g_slot
    logic shift_en;
    assign shift_en = upd_en && (!hit || (g <= int'(hit_pos)));

    always_ff @(posedge clk) begin
      if (shift_en) begin
        line_q[g] <= line_q[g-1];
        val_q[g]  <= val_q[g-1];
      end
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        vld_q[g] <= 1'b0;
      end else if (shift_en) begin
        vld_q[g] <= vld_q[g-1];
      end
    end
  end

  // R6: a line is never present in two slots.
  assert_single_copy_R6: assert property (@(posedge clk) disable iff (rst)
    $onehot0(match));

  // R6: the requested line becomes the most recent entry.
  assert_mru_insert_R6: assert property (@(posedge clk) disable iff (rst)
    upd_en |=> vld_q[0] && (line_q[0] == $past(lk_line)));

  // R6: a request that hits the window removes no entry.
  assert_hit_no_evict_R6: assert property (@(posedge clk) disable iff (rst)
    (upd_en && hit) |=> $countones(vld_q) == $countones($past(vld_q)));

endmodule

// File: rtl/abp_accum.sv
module abp_accum #(
  parameter int VAL_W = 16,
  parameter int ACC_W = 20,
  parameter int CNT_W = 3
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    upd_en,
  input  logic                    enter_en,
  input  logic [VAL_W-1:0]        enter_aff,
  input  logic                    leave_en,
  input  logic [VAL_W-1:0]        leave_aff,
  input  logic [CNT_W-1:0]        cnt_next,
  output logic [VAL_W-1:0]        drift_q,
  output logic signed [ACC_W-1:0] sum_q,
  output logic                    sum_neg
);

  localparam int EXT_W = ACC_W - VAL_W;

  logic signed [ACC_W-1:0] enter_x;
  logic signed [ACC_W-1:0] leave_x;
  logic signed [ACC_W-1:0] cnt_x;
  logic signed [ACC_W-1:0] sum_next;
  logic [VAL_W-1:0]        drift_next;

  assign sum_neg = sum_q[ACC_W-1];
  assign enter_x = enter_en ? {{EXT_W{enter_aff[VAL_W-1]}}, enter_aff} : '0;
  assign leave_x = leave_en ? {{EXT_W{leave_aff[VAL_W-1]}}, leave_aff} : '0;
  assign cnt_x   = {{(ACC_W-CNT_W){1'b0}}, cnt_next};

  always_comb begin
    drift_next = sum_neg ? drift_q - VAL_W'(1) : drift_q + VAL_W'(1);
    sum_next   = sum_q + enter_x - leave_x;
    sum_next   = sum_neg ? sum_next - cnt_x : sum_next + cnt_x;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      drift_q <= '0;
      sum_q   <= '0;
    end else if (upd_en) begin
      drift_q <= drift_next;
      sum_q   <= sum_next;
    end
  end

  // R4: a non-negative sum moves the drift up by one.
  assert_step_up_R4: assert property (@(posedge clk) disable iff (rst)
    (upd_en && !sum_neg) |=> drift_q == $past(drift_q) + VAL_W'(1));

  // R4/R5: a negative sum moves the drift down by one.
  assert_step_down_R5: assert property (@(posedge clk) disable iff (rst)
    (upd_en && sum_neg) |=> drift_q == $past(drift_q) - VAL_W'(1));

  // R8: idle cycles leave drift and sum untouched.
  assert_idle_stable_R8: assert property (@(posedge clk) disable iff (rst)
    !upd_en |=> $stable(drift_q) && $stable(sum_q));

endmodule

// File: rtl/abp_bipartitioner.sv
module abp_bipartitioner #(
  parameter int LINE_W = 8,
  parameter int IDX_W  = 4,
  parameter int WIN_N  = 4,
  parameter int VAL_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [LINE_W-1:0] req_line,
  output logic              rsp_valid,
  output logic [VAL_W-1:0]  rsp_affinity,
  output logic              rsp_sum_neg
);

  import abp_pkg::*;

  localparam int TAG_W = LINE_W - IDX_W;
  localparam int CNT_W = $clog2(WIN_N + 1);
  localparam int ACC_W = VAL_W + $clog2(WIN_N) + 2;

  logic [IDX_W-1:0]        req_idx;
  logic [TAG_W-1:0]        req_tag;
  logic                    win_hit;
  logic [VAL_W-1:0]        win_ival;
  logic                    ev_vld;
  logic [LINE_W-1:0]       ev_line;
  logic [VAL_W-1:0]        ev_ival;
  logic [CNT_W-1:0]        cnt_next;
  logic                    tbl_vld;
  logic [TAG_W-1:0]        tbl_tag;
  logic [VAL_W-1:0]        tbl_oval;
  logic [VAL_W-1:0]        drift;
  logic signed [ACC_W-1:0] win_sum;
  logic                    sum_neg;
  lookup_src_e             src;
  logic [VAL_W-1:0]        cur_aff;
  logic [VAL_W-1:0]        ins_ival;
  logic [VAL_W-1:0]        ev_aff;
  logic [VAL_W-1:0]        ev_oval;

  assign req_idx = req_line[IDX_W-1:0];
  assign req_tag = req_line[LINE_W-1:IDX_W];

  // Locate the requested line: window first, then its table slot.
  always_comb begin
    if (win_hit) begin
      src = LK_WINDOW;
    end else if (tbl_vld && (tbl_tag == req_tag)) begin
      src = LK_TABLE;
    end else begin
      src = LK_FRESH;
    end
    case (src)
      LK_WINDOW: cur_aff = win_ival + drift;
      LK_TABLE:  cur_aff = tbl_oval - drift;
      default:   cur_aff = '0;
    endcase
  end

  // Offset conversions, all relative to the drift before this request.
  assign ins_ival = cur_aff - drift;
  assign ev_aff   = ev_ival + drift;
  assign ev_oval  = ev_aff + drift;

  abp_window #(
    .WIN_N (WIN_N),
    .LINE_W(LINE_W),
    .VAL_W (VAL_W)
  ) win_i (
    .clk       (clk),
    .rst       (rst),
    .upd_en    (req_valid),
    .lk_line   (req_line),
    .ins_val   (ins_ival),
    .hit       (win_hit),
    .hit_val   (win_ival),
    .evict_vld (ev_vld),
    .evict_line(ev_line),
    .evict_val (ev_ival),
    .cnt_next  (cnt_next)
  );

  abp_table #(
    .IDX_W(IDX_W),
    .TAG_W(TAG_W),
    .VAL_W(VAL_W)
  ) tbl_i (
    .clk   (clk),
    .rst   (rst),
    .rd_idx(req_idx),
    .rd_vld(tbl_vld),
    .rd_tag(tbl_tag),
    .rd_val(tbl_oval),
    .wr_en (req_valid && ev_vld),
    .wr_idx(ev_line[IDX_W-1:0]),
    .wr_tag(ev_line[LINE_W-1:IDX_W]),
    .wr_val(ev_oval)
  );

  abp_accum #(
    .VAL_W(VAL_W),
    .ACC_W(ACC_W),
    .CNT_W(CNT_W)
  ) acc_i (
    .clk      (clk),
    .rst      (rst),
    .upd_en   (req_valid),
    .enter_en (!win_hit),
    .enter_aff(cur_aff),
    .leave_en (ev_vld),
    .leave_aff(ev_aff),
    .cnt_next (cnt_next),
    .drift_q  (drift),
    .sum_q    (win_sum),
    .sum_neg  (sum_neg)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid    <= 1'b0;
      rsp_affinity <= '0;
      rsp_sum_neg  <= 1'b0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_affinity <= cur_aff;
        rsp_sum_neg  <= sum_neg;
      end
    end
  end

  // R2: one response pulse per request, one cycle later.
  assert_rsp_pulse_R2: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);

  // R2: without a request the outputs hold and no pulse appears.
  assert_rsp_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid && $stable(rsp_affinity) && $stable(rsp_sum_neg));

  // R3: a line found nowhere reports affinity zero.
  assert_fresh_zero_R3: assert property (@(posedge clk) disable iff (rst)
    (req_valid && (src == LK_FRESH)) |=> rsp_affinity == '0);

  // R7: a window sum of zero drives the first request after reset positive.
  assert_sum_empty_R7: assert property (@(posedge clk) disable iff (rst)
    (req_valid && (win_sum == '0)) |=> !rsp_sum_neg);

endmodule

// File: tb/abp_bipartitioner_tb_top.sv
module abp_bipartitioner_tb_top;

  localparam int LINE_W = 6;
  localparam int IDX_W  = 3;
  localparam int WIN_N  = 4;
  localparam int VAL_W  = 16;
  localparam int SLOTS  = 1 << IDX_W;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              req_valid = 1'b0;
  logic [LINE_W-1:0] req_line = '0;
  logic              rsp_valid;
  logic [VAL_W-1:0]  rsp_affinity;
  logic              rsp_sum_neg;

  always #10 clk = ~clk;

  abp_bipartitioner #(
    .LINE_W(LINE_W),
    .IDX_W (IDX_W),
    .WIN_N (WIN_N),
    .VAL_W (VAL_W)
  ) dut_i (
    .clk         (clk),
    .rst         (rst),
    .req_valid   (req_valid),
    .req_line    (req_line),
    .rsp_valid   (rsp_valid),
    .rsp_affinity(rsp_affinity),
    .rsp_sum_neg (rsp_sum_neg)
  );

  int  n_cmp = 0;
  int  n_bad = 0;
  bit  done  = 1'b0;
  int  last_aff = 0;
  bit  last_neg = 1'b0;
  int  neg_seen = 0;

  // Reference model with direct per-line affinities.
  int  w_line [WIN_N];
  int  w_aff  [WIN_N];
  bit  w_vld  [WIN_N];
  int  t_line [SLOTS];
  int  t_aff  [SLOTS];
  bit  t_vld  [SLOTS];

  task automatic chk(input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  task automatic model_step(input int ln, output int aff, output bit neg);
    int sum = 0;
    int step;
    int pos = -1;
    for (int i = 0; i < WIN_N; i++) if (w_vld[i]) sum += w_aff[i];
    neg  = (sum < 0);
    step = neg ? -1 : 1;
    for (int i = 0; i < WIN_N; i++) if (w_vld[i] && w_line[i] == ln) pos = i;
    if (pos >= 0) begin
      aff = w_aff[pos];
      for (int i = pos; i > 0; i--) begin
        w_line[i] = w_line[i-1]; w_aff[i] = w_aff[i-1]; w_vld[i] = w_vld[i-1];
      end
    end else begin
      if (t_vld[ln % SLOTS] && t_line[ln % SLOTS] == ln) begin
        aff = t_aff[ln % SLOTS];
        t_vld[ln % SLOTS] = 1'b0;
      end else begin
        aff = 0;
      end
      if (w_vld[WIN_N-1]) begin
        t_vld[w_line[WIN_N-1] % SLOTS]  = 1'b1;
        t_line[w_line[WIN_N-1] % SLOTS] = w_line[WIN_N-1];
        t_aff[w_line[WIN_N-1] % SLOTS]  = w_aff[WIN_N-1];
      end
      for (int i = WIN_N - 1; i > 0; i--) begin
        w_line[i] = w_line[i-1]; w_aff[i] = w_aff[i-1]; w_vld[i] = w_vld[i-1];
      end
    end
    w_line[0] = ln; w_aff[0] = aff; w_vld[0] = 1'b1;
    for (int i = 0; i < WIN_N; i++) if (w_vld[i]) w_aff[i] += step;
    for (int i = 0; i < SLOTS; i++) if (t_vld[i]) t_aff[i] -= step;
  endtask

  // Starts at a falling edge; returns at the next one with the response checked.
  task automatic req(input int ln, input string tag);
    int ea;
    bit en;
    model_step(ln, ea, en);
    req_valid = 1'b1;
    req_line  = LINE_W'(ln);
    @(negedge clk);
    chk({tag, " (R2) rsp_valid"}, int'(rsp_valid), 1);
    chk({tag, " (R10) affinity"}, int'($signed(rsp_affinity)), ea);
    chk({tag, " (R4) sum sign"}, int'(rsp_sum_neg), int'(en));
    if (en) neg_seen++;
    last_aff = ea;
    last_neg = en;
  endtask

  task automatic idle(input string tag);
    req_valid = 1'b0;
    @(negedge clk);
    chk({tag, " (R2) no pulse"}, int'(rsp_valid), 0);
    chk({tag, " (R8) affinity held"}, int'($signed(rsp_affinity)), last_aff);
    chk({tag, " (R8) sign held"}, int'(rsp_sum_neg), int'(last_neg));
  endtask

  initial begin
    for (int i = 0; i < WIN_N; i++) begin w_line[i] = 0; w_aff[i] = 0; w_vld[i] = 1'b0; end
    for (int i = 0; i < SLOTS; i++) begin t_line[i] = 0; t_aff[i] = 0; t_vld[i] = 1'b0; end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 reset rsp_valid", int'(rsp_valid), 0);
    chk("R1 reset affinity", int'($signed(rsp_affinity)), 0);
    chk("R1 reset sum sign", int'(rsp_sum_neg), 0);
    idle("R8 idle after reset");

    // R3: the very first line is unknown everywhere.
    req(5, "R3 first line");
    chk("R3 first line zero", last_aff, 0);
    idle("R2 gap");

    // R5: circular sweep over more lines than the window holds.
    for (int r = 0; r < 20; r++)
      for (int l = 0; l < 12; l++) req(l, "R5 circular");
    idle("R2 gap");

    // R6: four lines that stay in the window; the table keeps falling.
    for (int r = 0; r < 60; r++) begin
      req(40, "R6 window hit"); req(41, "R6 window hit");
      req(42, "R6 window hit"); req(40, "R6 window hit");
      req(43, "R6 window hit");
    end

    // R7/R9: pull the parked negative lines back in to flip the sum.
    for (int r = 0; r < 3; r++)
      for (int l = 0; l < 12; l++) req(l, "R9 parked lines");
    idle("R2 gap");

    // R3/R9: several lines share table slot 3.
    for (int r = 0; r < 15; r++) begin
      req(3, "R9 slot conflict");  req(11, "R9 slot conflict");
      req(19, "R9 slot conflict"); req(27, "R9 slot conflict");
      req(35, "R3 slot conflict"); req(6, "R9 slot conflict");
    end
    idle("R2 gap");

    // R7: pseudo-random stream with idle gaps.
    begin
      int lf = 16'hACE1;
      for (int k = 0; k < 1500; k++) begin
        lf = (lf >> 1) ^ ((lf & 1) != 0 ? 16'hB400 : 0);
        req(lf & 63, "R7 random stream");
        if (k % 7 == 6) idle("R8 random gap");
      end
    end
    idle("R2 final gap");
    chk("R4 negative sum reached", int'(neg_seen > 0), 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    done = 1'b1;
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule